// File: doc/BRIEF.md
# UART interrupt and status controller

This block is the register-mapped status, interrupt and modem-control unit of a small FIFO-based UART. The FIFOs, the serializer and the deserializer live outside it and reach it only through level condition inputs, a receive-timeout strobe, a byte bus for the receive data, and flush and pop strobes. It turns every condition into a sticky flag. Software acknowledges a flag by writing a one to its bit. The flags are masked by an enable register, and the result is folded into one registered interrupt line.

The same block holds a control register. That register drives the ready-to-send output and issues one-cycle flush strobes to the receive and transmit FIFOs. It also shows the clear-to-send input after a two-flop synchronizer. Every change of the synchronized clear-to-send level raises its own sticky flag, so a modem-status change can raise an interrupt.

The bus side is a 32-bit register port with word-aligned byte addresses. Writes take effect at the clock edge where the write strobe is high. Read data is captured at the edge where the read strobe is high and is held until the next read.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, all flags, the enable register, the interrupt output, the ready-to-send output, the flush and pop strobes and the read data are zero.
- R2: Writing to the status register clears each flag whose write-data bit is 1. A 0 bit leaves its flag unchanged. Writing 0x1FF clears all nine flags at once.
- R3: When a condition is active in the same cycle as a clear of its flag, the set wins. A level condition that stays active keeps its flag at 1.
- R4: Status bit positions are: bit 0 receive data available, bit 1 receive nearly full, bit 2 receive full, bit 3 receive idle timeout, bit 4 transmit full, bit 5 transmit nearly full, bit 6 transmit empty, bit 7 transmit nearly empty, bit 8 clear-to-send changed. A one-cycle pulse on any condition leaves its bit set.
- R5: The interrupt output is registered. It rises one cycle after a flag whose enable bit is set becomes 1. The pending register (offset 0x08) reads the interrupt output in bit 0.
- R6: A flag whose enable bit is 0 never raises the interrupt. The enable register sits at offset 0x04 with the same bit layout as the status register. Writing 0 to it drops the interrupt one cycle after the write edge.
- R7: The clear-to-send input passes two synchronizer flops. Each synchronized level change sets status bit 8 exactly once. The control register bit 3 reads the synchronized level.
- R8: Control register (offset 0x0C) bit 2 is the ready-to-send bit. It can be written and read back, and it drives rts_o. Writing 1 to bit 0 or bit 1 gives a one-cycle pulse on the receive or transmit flush output in the cycle after the write edge. Both flush bits read back as 0.
- R9: A read of offset 0x10 returns rx_byte_i in bits 7:0 and pulses rx_pop_o during the read cycle. A read of any other offset leaves rx_pop_o low.
- R10: The register index is the byte address shifted right by 2. The status register is at offset 0x00. Reads of unmapped offsets return 0. Writes to unmapped or read-only offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_avail_i | input | 1 | Receive FIFO not empty |
| rx_nearfull_i | input | 1 | Receive FIFO nearly full |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_idle_i | input | 1 | Receive timeout strobe |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_nearfull_i | input | 1 | Transmit FIFO nearly full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_nearempty_i | input | 1 | Transmit FIFO nearly empty |
| rx_byte_i | input | 8 | Byte at the head of the receive FIFO |
| cts_i | input | 1 | Asynchronous clear-to-send input |
| rx_pop_o | output | 1 | Pops the receive FIFO head |
| rx_flush_o | output | 1 | Empties the receive FIFO |
| tx_flush_o | output | 1 | Empties the transmit FIFO |
| rts_o | output | 1 | Ready-to-send output |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions watch several rules on every cycle:
- the set-over-clear priority and the write-one-to-clear behaviour of each flag;
- the interrupt staying low whenever the enable register is zero, and rising after an enabled flag goes high;
- the ready-to-send and enable registers holding their values without a write to them;
- a synchronized clear-to-send edge always reaching its flag.

Only the bench scenarios can show the rest:
- the absolute bit position of each condition;
- the two-cycle latency through the synchronizer;
- the single flag set per clear-to-send change;
- the flush pulse width, the pop strobe and the address decode of unmapped offsets.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned NUM_FLAGS = 9;

  localparam int unsigned F_RX_AVAIL     = 0;
  localparam int unsigned F_RX_NEARFULL  = 1;
  localparam int unsigned F_RX_FULL      = 2;
  localparam int unsigned F_RX_IDLE      = 3;
  localparam int unsigned F_TX_FULL      = 4;
  localparam int unsigned F_TX_NEARFULL  = 5;
  localparam int unsigned F_TX_EMPTY     = 6;
  localparam int unsigned F_TX_NEAREMPTY = 7;
  localparam int unsigned F_CTS_CHG      = 8;

  localparam int unsigned C_FLUSH_RX = 0;
  localparam int unsigned C_FLUSH_TX = 1;
  localparam int unsigned C_RTS      = 2;
  localparam int unsigned C_CTS      = 3;

  typedef enum logic [2:0] {
    RI_STATUS  = 3'd0,
    RI_ENABLE  = 3'd1,
    RI_PENDING = 3'd2,
    RI_CONTROL = 3'd3,
    RI_RXDATA  = 3'd4
  } reg_idx_e;

endpackage

// File: rtl/uart_irq_cts_sync.sv
module uart_irq_cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sync_d[g] = async_i;
    end else begin : g_chain
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign edge_o  = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/uart_irq_flag_bank.sv
module uart_irq_flag_bank #(
  parameter int unsigned NF = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] mask_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);

  logic [NF-1:0] flag_q, flag_d;
  logic          irq_q, irq_d;

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);
    end
    irq_d = |(flag_q & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = irq_q;

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flag_q ^ $past(flag_q)) & ~$past(set_i | clr_i)) == '0));

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|(flag_q & mask_i)) |=> irq_q);

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> !irq_q);

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned NF    = 9,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned DW    = 32,
  parameter int unsigned BW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] word_idx,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NF-1:0]    flags_i,
  input  logic             irq_i,
  input  logic             cts_lvl_i,
  input  logic [BW-1:0]    rx_byte_i,
  output logic [NF-1:0]    clr_o,
  output logic [NF-1:0]    mask_o,
  output logic             rts_o,
  output logic             rx_flush_o,
  output logic             tx_flush_o,
  output logic             rx_pop_o,
  output logic [DW-1:0]    rdata_o
);

  logic sel_stat, sel_mask, sel_pend, sel_ctrl, sel_data;

  assign sel_stat = (word_idx == IDX_W'(RI_STATUS));
  assign sel_mask = (word_idx == IDX_W'(RI_ENABLE));
  assign sel_pend = (word_idx == IDX_W'(RI_PENDING));
  assign sel_ctrl = (word_idx == IDX_W'(RI_CONTROL));
  assign sel_data = (word_idx == IDX_W'(RI_RXDATA));

  logic [NF-1:0] mask_q, mask_d;
  logic          rts_q, rts_d;
  logic          rxf_q, rxf_d;
  logic          txf_q, txf_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [DW-1:0] rd_mux;
  logic          mask_we, ctrl_we;

  assign mask_we = wr_i & sel_mask;
  assign ctrl_we = wr_i & sel_ctrl;

  always_comb begin
    mask_d = mask_q;
    rts_d  = rts_q;
    rxf_d  = 1'b0;
    txf_d  = 1'b0;
    if (mask_we) begin
      mask_d = wdata_i[NF-1:0];
    end
    if (ctrl_we) begin
      rts_d = wdata_i[C_RTS];
      rxf_d = wdata_i[C_FLUSH_RX];
      txf_d = wdata_i[C_FLUSH_TX];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_stat) begin
      rd_mux[NF-1:0] = flags_i;
    end else if (sel_mask) begin
      rd_mux[NF-1:0] = mask_q;
    end else if (sel_pend) begin
      rd_mux[0] = irq_i;
    end else if (sel_ctrl) begin
      rd_mux[C_RTS] = rts_q;
      rd_mux[C_CTS] = cts_lvl_i;
    end else if (sel_data) begin
      rd_mux[BW-1:0] = rx_byte_i;
    end
    rdata_d = rd_i ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rts_q   <= 1'b0;
      rxf_q   <= 1'b0;
      txf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      rts_q   <= rts_d;
      rxf_q   <= rxf_d;
      txf_q   <= txf_d;
      rdata_q <= rdata_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DW-1:NF];

  assign clr_o      = (wr_i && sel_stat) ? wdata_i[NF-1:0] : '0;
  assign mask_o     = mask_q;
  assign rts_o      = rts_q;
  assign rx_flush_o = rxf_q;
  assign tx_flush_o = txf_q;
  assign rx_pop_o   = rd_i & sel_data;
  assign rdata_o    = rdata_q;

  p_rts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(rts_q));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_q));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned CTS_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_avail_i,
  input  logic              rx_nearfull_i,
  input  logic              rx_full_i,
  input  logic              rx_idle_i,
  input  logic              tx_full_i,
  input  logic              tx_nearfull_i,
  input  logic              tx_empty_i,
  input  logic              tx_nearempty_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              cts_i,
  output logic              rx_pop_o,
  output logic              rx_flush_o,
  output logic              tx_flush_o,
  output logic              rts_o,
  output logic              irq_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned NF    = NUM_FLAGS;

  logic [IDX_W-1:0] word_idx;
  logic             unused_addr_lsb;
  logic             cts_lvl, cts_edge;
  logic [NF-1:0]    set_vec, clr_vec, mask_vec, flag_vec;
  logic             irq_w;

  assign word_idx        = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  uart_irq_cts_sync #(.STAGES(CTS_STAGES)) u_cts (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cts_i),
    .level_o (cts_lvl),
    .edge_o  (cts_edge)
  );

  always_comb begin
    set_vec                 = '0;
    set_vec[F_RX_AVAIL]     = rx_avail_i;
    set_vec[F_RX_NEARFULL]  = rx_nearfull_i;
    set_vec[F_RX_FULL]      = rx_full_i;
    set_vec[F_RX_IDLE]      = rx_idle_i;
    set_vec[F_TX_FULL]      = tx_full_i;
    set_vec[F_TX_NEARFULL]  = tx_nearfull_i;
    set_vec[F_TX_EMPTY]     = tx_empty_i;
    set_vec[F_TX_NEAREMPTY] = tx_nearempty_i;
    set_vec[F_CTS_CHG]      = cts_edge;
  end

  uart_irq_flag_bank #(.NF(NF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .mask_i  (mask_vec),
    .flags_o (flag_vec),
    .irq_o   (irq_w)
  );

  uart_irq_regs #(.NF(NF), .IDX_W(IDX_W), .DW(DATA_W), .BW(BYTE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_idx   (word_idx),
    .wr_i       (bus_wr),
    .rd_i       (bus_rd),
    .wdata_i    (bus_wdata),
    .flags_i    (flag_vec),
    .irq_i      (irq_w),
    .cts_lvl_i  (cts_lvl),
    .rx_byte_i  (rx_byte_i),
    .clr_o      (clr_vec),
    .mask_o     (mask_vec),
    .rts_o      (rts_o),
    .rx_flush_o (rx_flush_o),
    .tx_flush_o (tx_flush_o),
    .rx_pop_o   (rx_pop_o),
    .rdata_o    (bus_rdata)
  );

  assign irq_o = irq_w;

  p_cts_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cts_edge |=> flag_vec[F_CTS_CHG]);

endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  cond;
  logic [7:0]  rxb;
  logic        cts;
  logic        pop, rxfl, txfl, rts, irq;

  always #10 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .rx_avail_i(cond[0]), .rx_nearfull_i(cond[1]), .rx_full_i(cond[2]),
    .rx_idle_i(cond[3]), .tx_full_i(cond[4]), .tx_nearfull_i(cond[5]),
    .tx_empty_i(cond[6]), .tx_nearempty_i(cond[7]),
    .rx_byte_i(rxb), .cts_i(cts), .rx_pop_o(pop), .rx_flush_o(rxfl),
    .tx_flush_o(txfl), .rts_o(rts), .irq_o(irq)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares captured read data against queued expectations
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen === 1'b1 && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata === e, t, rdata, e);
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    #1;
    chk(pop === (a == 5'h10), "R9 pop strobe", {31'd0, pop}, {31'd0, (a == 5'h10)});
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    cond = '0; rxb = '0; cts = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);
    chk(rts === 1'b0, "R1 rts", {31'd0, rts}, 0);
    chk(rxfl === 1'b0 && txfl === 1'b0, "R1 flush", {30'd0, txfl, rxfl}, 0);
    chk(rdata === 32'd0, "R1 rdata", rdata, 0);
    rd_reg(5'h00, 32'h0, "R1 status");
    rd_reg(5'h04, 32'h0, "R1 enable");
    rd_reg(5'h08, 32'h0, "R1 pending");
    rd_reg(5'h0C, 32'h0, "R1 control");

    // R4 bit position of each condition, R2 single clear
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); cond = 8'(1 << i);
      @(negedge clk); cond = 8'h00;
      rd_reg(5'h00, 32'(1 << i), "R4 flag position");
      wr_reg(5'h00, 32'(1 << i));
      rd_reg(5'h00, 32'h0, "R2 single clear");
    end

    // R2 zero bits leave flags, all-ones clears
    @(negedge clk); cond = 8'h22;
    @(negedge clk); cond = 8'h00;
    wr_reg(5'h00, 32'h002);
    rd_reg(5'h00, 32'h020, "R2 zero bit keeps flag");
    wr_reg(5'h00, 32'h1FF);
    rd_reg(5'h00, 32'h0, "R2 clear all");

    // R3 set wins against clear
    @(negedge clk); cond = 8'h01;
    wr_reg(5'h00, 32'h001);
    rd_reg(5'h00, 32'h001, "R3 level keeps flag");
    cond = 8'h00;
    wr_reg(5'h00, 32'h001);
    rd_reg(5'h00, 32'h0, "R3 clear after level drops");

    // R5 interrupt timing
    wr_reg(5'h04, 32'h004);
    rd_reg(5'h04, 32'h004, "R6 enable readback");
    @(negedge clk); cond = 8'h04;
    @(negedge clk); cond = 8'h00;
    chk(irq === 1'b0, "R5 irq not yet", {31'd0, irq}, 0);
    tick(1);
    chk(irq === 1'b1, "R5 irq one cycle later", {31'd0, irq}, 1);
    rd_reg(5'h08, 32'h1, "R5 pending register");

    // R6 masking
    wr_reg(5'h04, 32'h0);
    tick(1);
    chk(irq === 1'b0, "R6 irq drops after disable", {31'd0, irq}, 0);
    rd_reg(5'h00, 32'h004, "R6 flag kept while masked");
    wr_reg(5'h04, 32'h010);
    tick(2);
    chk(irq === 1'b0, "R6 masked flag silent", {31'd0, irq}, 0);
    @(negedge clk); cond = 8'h10;
    @(negedge clk); cond = 8'h00;
    tick(1);
    chk(irq === 1'b1, "R6 enabled flag raises", {31'd0, irq}, 1);
    wr_reg(5'h00, 32'h1FF);
    wr_reg(5'h04, 32'h0);
    tick(2);
    chk(irq === 1'b0, "R6 idle", {31'd0, irq}, 0);

    // R7 clear-to-send change
    @(negedge clk); cts = 1'b1;
    tick(4);
    rd_reg(5'h00, 32'h100, "R7 rise sets flag");
    rd_reg(5'h0C, 32'h008, "R7 cts level");
    wr_reg(5'h00, 32'h100);
    tick(4);
    rd_reg(5'h00, 32'h0, "R7 set only once");
    @(negedge clk); cts = 1'b0;
    tick(4);
    rd_reg(5'h00, 32'h100, "R7 fall sets flag");
    rd_reg(5'h0C, 32'h000, "R7 cts low");
    wr_reg(5'h00, 32'h1FF);
    wr_reg(5'h04, 32'h100);
    @(negedge clk); cts = 1'b1;
    tick(3);
    chk(irq === 1'b0, "R7 sync latency", {31'd0, irq}, 0);
    tick(1);
    chk(irq === 1'b1, "R7 irq after sync", {31'd0, irq}, 1);
    wr_reg(5'h00, 32'h1FF);
    wr_reg(5'h04, 32'h0);
    tick(2);

    // R8 control register
    wr_reg(5'h0C, 32'h4);
    chk(rts === 1'b1, "R8 rts set", {31'd0, rts}, 1);
    rd_reg(5'h0C, 32'h00C, "R8 control readback");
    @(negedge clk); addr = 5'h0C; wdata = 32'h5; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk(rxfl === 1'b1 && txfl === 1'b0, "R8 rx flush pulse", {30'd0, txfl, rxfl}, 32'h1);
    tick(1);
    chk(rxfl === 1'b0, "R8 rx flush one cycle", {31'd0, rxfl}, 0);
    @(negedge clk); addr = 5'h0C; wdata = 32'h6; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk(txfl === 1'b1 && rxfl === 1'b0, "R8 tx flush pulse", {30'd0, txfl, rxfl}, 32'h2);
    tick(1);
    chk(txfl === 1'b0, "R8 tx flush one cycle", {31'd0, txfl}, 0);
    rd_reg(5'h0C, 32'h00C, "R8 flush bits read zero");
    wr_reg(5'h0C, 32'h0);
    chk(rts === 1'b0, "R8 rts clear", {31'd0, rts}, 0);

    // R9 receive data
    rxb = 8'hA5;
    rd_reg(5'h10, 32'h0A5, "R9 data byte");
    rxb = 8'h3C;
    rd_reg(5'h10, 32'h03C, "R9 second byte");
    rd_reg(5'h00, 32'h0, "R9 status read no pop");

    // R10 address decode
    rd_reg(5'h14, 32'h0, "R10 unmapped read");
    rd_reg(5'h1C, 32'h0, "R10 unmapped read high");
    wr_reg(5'h08, 32'hFFFF_FFFF);
    wr_reg(5'h14, 32'h1FF);
    rd_reg(5'h04, 32'h0, "R10 enable untouched");
    rd_reg(5'h00, 32'h0, "R10 status untouched");
    chk(irq === 1'b0, "R10 irq quiet", {31'd0, irq}, 0);

    tick(2);
    summary();
    $finish;
  end

endmodule